// File: doc/BRIEF.md
# Two-Wire Bus Ownership and Error Monitor

This block sits beside a two-wire (I2C) master engine. It watches the SDA and SCL lines, which reach it already synchronized to the system clock, and keeps a two-bit view of who owns the shared bus: unknown, idle, owned by this master, or busy with another master. From the engine it takes the level the master is trying to put on SDA and whether a START or repeated START is being issued. From these inputs it detects lost arbitration and tells the engine to stop driving until the bus is released.

It also keeps two sticky error flags. One is for lost arbitration. The other is for an illegal bus condition: a START or STOP that arrives part-way through a nine-bit frame. It also holds the last acknowledge bit sampled from the addressed device. Software-side strobes clear the flags one at a time, clear both through an address-write strobe, or force the ownership view to idle. Every pin is a plain level or a one-cycle strobe. No data stream passes through the block, so no valid/ready pair is used and no back-pressure applies.

Top module: `i2cmon_top`

## Requirements
- R1: While reset is active the state output is 00 (unknown), both flags are 0 and the acknowledge flag is 0. While `enable` is low the state returns to 00 at the next edge, and the release request is dropped.
- R2: A START is SDA going 1 to 0 while SCL is 1 on two consecutive samples. A STOP is SDA going 0 to 1 while SCL is 1 on two consecutive samples. The state updates at the clock edge that takes the second sample. A START seen in idle (01) moves to owner (10) if `start_req` is 1, else to busy (11). A STOP seen in idle, owner or busy moves to idle.
- R3: A `state_wr` strobe with `state_wdata` = 01 forces the state to 01 at the next edge, from any state, and drops the release request. A strobe with any other value leaves the state unchanged.
- R4: In state 00 with `enable` high, once SDA and SCL have both been 1 for TIMEOUT_CYCLES consecutive edges, the state moves to 01 on that edge. TIMEOUT_CYCLES = 0 removes this path.
- R5: Frame bits are counted on SCL 1-to-0 transitions. The first such transition after a START belongs to the START and is not counted. If a START or STOP arrives while the count is not a multiple of FRAME_BITS (9), `bus_err` is set.
- R6: `arb_lost` is set, the state goes to 11 and `hold_off` rises in two cases, provided the state is 01 or 10 and `hold_off` is low. The first case is an SCL 0-to-1 transition with `drv_active` and `drv_bit` both 1 and SDA read 0. The second is SCL at 1 with `start_req` and `drv_bit` both 1 and SDA read 0.
- R7: `hold_off` stays 1 until a STOP, a forced idle or `enable` going low, and it is 1 only while the state is 11.
- R8: Both flags are sticky. `clr_arb` clears `arb_lost`, `clr_berr` clears `bus_err`, and `addr_wr` clears both. A set in the same cycle wins over a clear.
- R9: On an SCL 0-to-1 transition with `ack_phase` high, `ack_flag` takes the SDA level (0 = ACK, 1 = NACK). At any other time it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Monitor enable; low holds the state unknown |
| sda_in | input | 1 | Synchronized SDA level |
| scl_in | input | 1 | Synchronized SCL level |
| start_req | input | 1 | Master engine is issuing a START or repeated START |
| drv_active | input | 1 | Master engine drives the current data or acknowledge bit |
| drv_bit | input | 1 | Level the master wants on SDA (1 = released) |
| ack_phase | input | 1 | Current SCL pulse carries the device's acknowledge bit |
| state_wr | input | 1 | Strobe: write to the state field |
| state_wdata | input | 2 | Value written with `state_wr` |
| clr_arb | input | 1 | Strobe: clear `arb_lost` |
| clr_berr | input | 1 | Strobe: clear `bus_err` |
| addr_wr | input | 1 | Strobe: address written, clears both flags |
| bus_state | output | 2 | 00 unknown, 01 idle, 10 owner, 11 busy |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| bus_err | output | 1 | Sticky illegal-condition flag |
| ack_flag | output | 1 | Last sampled acknowledge bit |
| hold_off | output | 1 | Master must release the bus until STOP |

## Verification
The bench builds the block with FRAME_BITS = 9 and TIMEOUT_CYCLES = 16. The short timeout lets the unknown-to-idle path be checked at the exact edge, both after reset and after re-enabling, within a few dozen cycles. With the standard nine-bit frame, a full address-plus-NACK frame followed by a repeated START can be shown to be legal. A data byte cut short after losing arbitration then ends in a STOP that must raise the bus error.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  typedef enum logic [1:0] {
    BS_UNKNOWN = 2'b00,
    BS_IDLE    = 2'b01,
    BS_OWNER   = 2'b10,
    BS_BUSY    = 2'b11
  } bus_state_e;
endpackage

// File: rtl/i2cmon_line_events.sv
module i2cmon_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic sda,
  input  logic scl,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic sda_q, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda;
      scl_q <= scl;
    end
  end

  // conditions need SCL high on both samples
  always_comb begin
    start_ev = scl & scl_q & sda_q & ~sda;
    stop_ev  = scl & scl_q & ~sda_q & sda;
    scl_rise = scl & ~scl_q;
    scl_fall = ~scl & scl_q;
  end
endmodule

// File: rtl/i2cmon_frame_count.sv
module i2cmon_frame_count #(
  parameter int FRAME_BITS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_ev,
  input  logic stop_ev,
  input  logic scl_fall,
  output logic frame_bad
);
  localparam int CW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!enable || start_ev || stop_ev) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (scl_fall) begin
      if (!armed) armed <= 1'b1;
      else        cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign frame_bad = enable & (start_ev | stop_ev) & (cnt != '0);
endmodule

// File: rtl/i2cmon_state_fsm.sv
module i2cmon_state_fsm
  import i2cmon_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       sda,
  input  logic       scl,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       own_start,
  input  logic       force_idle,
  input  logic       arb_ev,
  output bus_state_e state,
  output logic       hold_off
);
  logic tmo_hit;

  generate
    if (TIMEOUT_CYCLES > 0) begin : g_tmo
      localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
      logic [TW-1:0] tcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tcnt <= '0;
        else if (enable && state == BS_UNKNOWN && sda && scl && !tmo_hit)
          tcnt <= tcnt + 1'b1;
        else
          tcnt <= '0;
      end
      assign tmo_hit = sda & scl & (tcnt == TW'(TIMEOUT_CYCLES - 1));
    end else begin : g_no_tmo
      assign tmo_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= BS_UNKNOWN;
      hold_off <= 1'b0;
    end else if (!enable) begin
      state    <= BS_UNKNOWN;
      hold_off <= 1'b0;
    end else if (force_idle) begin
      state    <= BS_IDLE;
      hold_off <= 1'b0;
    end else if (arb_ev) begin
      state    <= BS_BUSY;
      hold_off <= 1'b1;
    end else if (stop_ev && state != BS_UNKNOWN) begin
      state    <= BS_IDLE;
      hold_off <= 1'b0;
    end else if (start_ev && state == BS_IDLE) begin
      state <= own_start ? BS_OWNER : BS_BUSY;
    end else if (state == BS_UNKNOWN && tmo_hit) begin
      state <= BS_IDLE;
    end
  end
endmodule

// File: rtl/i2cmon_top.sv
module i2cmon_top
  import i2cmon_pkg::*;
#(
  parameter int FRAME_BITS     = 9,
  parameter int TIMEOUT_CYCLES = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       start_req,
  input  logic       drv_active,
  input  logic       drv_bit,
  input  logic       ack_phase,
  input  logic       state_wr,
  input  logic [1:0] state_wdata,
  input  logic       clr_arb,
  input  logic       clr_berr,
  input  logic       addr_wr,
  output logic [1:0] bus_state,
  output logic       arb_lost,
  output logic       bus_err,
  output logic       ack_flag,
  output logic       hold_off
);
  logic start_ev, stop_ev, scl_rise, scl_fall;
  logic frame_bad, arb_ev, force_idle;
  bus_state_e state;

  i2cmon_line_events u_ev (
    .clk(clk), .rst_n(rst_n), .sda(sda_in), .scl(scl_in),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2cmon_frame_count #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .start_ev(start_ev), .stop_ev(stop_ev), .scl_fall(scl_fall),
    .frame_bad(frame_bad)
  );

  assign force_idle = state_wr & (state_wdata == 2'b01);

  // master releases SDA but reads it low: during a bit or while starting
  assign arb_ev = enable & ~hold_off & drv_bit & ~sda_in &
                  (state == BS_IDLE || state == BS_OWNER) &
                  ((drv_active & scl_rise) | (start_req & scl_in));

  i2cmon_state_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .sda(sda_in), .scl(scl_in),
    .start_ev(start_ev), .stop_ev(stop_ev), .own_start(start_req),
    .force_idle(force_idle), .arb_ev(arb_ev),
    .state(state), .hold_off(hold_off)
  );

  assign bus_state = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_lost <= 1'b0;
      bus_err  <= 1'b0;
      ack_flag <= 1'b0;
    end else begin
      if (arb_ev)                  arb_lost <= 1'b1;
      else if (clr_arb || addr_wr) arb_lost <= 1'b0;
      if (frame_bad)                bus_err <= 1'b1;
      else if (clr_berr || addr_wr) bus_err <= 1'b0;
      if (enable && scl_rise && ack_phase) ack_flag <= sda_in;
    end
  end
endmodule

// File: rtl/i2cmon_checker.sv
module i2cmon_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       state_wr,
  input logic [1:0] state_wdata,
  input logic       clr_arb,
  input logic       clr_berr,
  input logic       addr_wr,
  input logic       ack_phase,
  input logic [1:0] bus_state,
  input logic       arb_lost,
  input logic       bus_err,
  input logic       ack_flag,
  input logic       hold_off
);
  a_r1_off_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> bus_state == 2'b00);

  a_r3_force_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state_wr && state_wdata == 2'b01) |=> bus_state == 2'b01);

  a_r7_hold_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    hold_off |-> bus_state == 2'b11);

  a_r8_arb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arb_lost) |-> $past(clr_arb || addr_wr));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_err) |-> $past(clr_berr || addr_wr));

  a_r9_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_phase |=> $stable(ack_flag));
endmodule

bind i2cmon_top i2cmon_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .state_wr(state_wr), .state_wdata(state_wdata),
  .clr_arb(clr_arb), .clr_berr(clr_berr), .addr_wr(addr_wr),
  .ack_phase(ack_phase), .bus_state(bus_state),
  .arb_lost(arb_lost), .bus_err(bus_err),
  .ack_flag(ack_flag), .hold_off(hold_off)
);

// File: tb/i2cmon_top_tb_top.sv
`timescale 1ns/1ps
module i2cmon_top_tb_top;
  localparam int TMO = 16;
  localparam int NV  = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic sda = 1'b1, scl = 1'b1;
  logic sr = 1'b0, da = 1'b0, db = 1'b1, ak = 1'b0;
  logic swr = 1'b0;
  logic [1:0] swd = 2'b00;
  logic c_arb = 1'b0, c_err = 1'b0, awr = 1'b0;
  logic [1:0] st;
  logic arb, err, ack, hold;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  i2cmon_top #(.FRAME_BITS(9), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .sda_in(sda), .scl_in(scl), .start_req(sr),
    .drv_active(da), .drv_bit(db), .ack_phase(ak),
    .state_wr(swr), .state_wdata(swd),
    .clr_arb(c_arb), .clr_berr(c_err), .addr_wr(awr),
    .bus_state(st), .arb_lost(arb), .bus_err(err),
    .ack_flag(ack), .hold_off(hold)
  );

  // {sda,scl,start_req,drv_active,drv_bit,ack_phase, state[1:0], arb,err,ack,hold}
  localparam logic [11:0] VEC [0:NV-1] = '{
    12'b1_1_1_0_1_0_01_0_0_0_0,  // idle, master ready to start
    12'b0_1_1_0_0_0_10_0_0_0_0,  // own START -> owner
    12'b0_0_0_0_0_0_10_0_0_0_0,  // SCL low (start hold, not counted)
    12'b1_0_0_1_1_0_10_0_0_0_0,  // addr bit 1
    12'b1_1_0_1_1_0_10_0_0_0_0,
    12'b0_0_0_1_0_0_10_0_0_0_0,  // addr bit 0
    12'b0_1_0_1_0_0_10_0_0_0_0,
    12'b1_0_0_1_1_0_10_0_0_0_0,  // addr bit 1
    12'b1_1_0_1_1_0_10_0_0_0_0,
    12'b0_0_0_1_0_0_10_0_0_0_0,  // addr bits 0 x5
    12'b0_1_0_1_0_0_10_0_0_0_0,
    12'b0_0_0_1_0_0_10_0_0_0_0,
    12'b0_1_0_1_0_0_10_0_0_0_0,
    12'b0_0_0_1_0_0_10_0_0_0_0,
    12'b0_1_0_1_0_0_10_0_0_0_0,
    12'b0_0_0_1_0_0_10_0_0_0_0,
    12'b0_1_0_1_0_0_10_0_0_0_0,
    12'b0_0_0_1_0_0_10_0_0_0_0,
    12'b0_1_0_1_0_0_10_0_0_0_0,
    12'b1_0_0_0_0_1_10_0_0_0_0,  // ack slot, device leaves SDA high
    12'b1_1_0_0_0_1_10_0_0_1_0,  // NACK captured
    12'b1_0_0_0_0_0_10_0_0_1_0,  // 9th fall: frame complete
    12'b1_1_1_0_1_0_10_0_0_1_0,  // SCL up for repeated START
    12'b0_1_1_0_0_0_10_0_0_1_0,  // repeated START, legal
    12'b0_0_0_0_0_0_10_0_0_1_0,
    12'b1_0_0_1_1_0_10_0_0_1_0,  // master sends 1
    12'b0_1_0_1_1_0_11_1_0_1_1,  // reads 0 at SCL rise: arbitration lost
    12'b0_0_0_0_0_0_11_1_0_1_1,  // one bit counted
    12'b0_1_0_0_0_0_11_1_0_1_1,
    12'b1_1_0_0_0_0_01_1_1_1_0   // STOP mid-frame: bus error, idle
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic lines(input logic s_da, input logic s_cl);
    @(negedge clk); sda = s_da; scl = s_cl;
    cyc();
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    // R1 reset state
    chk("R1 reset state", {2'b0, st}, 4'h0);
    chk("R1 reset flags", {1'b0, arb, err, ack}, 4'h0);
    repeat (2) cyc();
    @(negedge clk); rst_n = 1'b1;
    // R4 timeout after reset: 15 edges unknown, 16th idle
    repeat (TMO - 1) cyc();
    chk("R4 still unknown", {2'b0, st}, 4'h0);
    cyc();
    chk("R4 timeout idle", {2'b0, st}, 4'h1);

    // table walk: R2 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {sda, scl, sr, da, db, ak} = VEC[i][11:6];
      cyc();
      chk($sformatf("R2 table state step %0d", i), {2'b0, st}, {2'b0, VEC[i][5:4]});
      chk($sformatf("R6 table arb step %0d", i), {3'b0, arb}, {3'b0, VEC[i][3]});
      chk($sformatf("R5 table err step %0d", i), {3'b0, err}, {3'b0, VEC[i][2]});
      chk($sformatf("R9 table ack step %0d", i), {3'b0, ack}, {3'b0, VEC[i][1]});
      chk($sformatf("R7 table hold step %0d", i), {3'b0, hold}, {3'b0, VEC[i][0]});
    end
    @(negedge clk); {sr, da, db, ak} = 4'b0010;

    // R8 separate and joint clears
    @(negedge clk); c_arb = 1'b1; cyc(); #1 c_arb = 1'b0;
    chk("R8 clr_arb clears arb", {3'b0, arb}, 4'h0);
    chk("R8 clr_arb keeps err", {3'b0, err}, 4'h1);
    @(negedge clk); awr = 1'b1; cyc(); #1 awr = 1'b0;
    chk("R8 addr_wr clears err", {3'b0, err}, 4'h0);

    // R2 foreign START -> busy
    lines(1'b0, 1'b1);
    chk("R2 foreign start busy", {2'b0, st}, 4'h3);
    chk("R6 no arb on foreign start", {3'b0, arb}, 4'h0);
    // R3 non-01 writes ignored
    @(negedge clk); swr = 1'b1; swd = 2'b10; cyc();
    chk("R3 write 10 ignored", {2'b0, st}, 4'h3);
    @(negedge clk); swd = 2'b00; cyc();
    chk("R3 write 00 ignored", {2'b0, st}, 4'h3);
    @(negedge clk); swd = 2'b01; cyc();
    @(negedge clk); swr = 1'b0;
    chk("R3 write 01 forces idle", {2'b0, st}, 4'h1);
    lines(1'b1, 1'b1);  // STOP while idle, empty frame
    chk("R5 empty frame no error", {3'b0, err}, 4'h0);

    // R6 disturbed START
    @(negedge clk); sr = 1'b1; db = 1'b1; sda = 1'b0; cyc();
    chk("R6 start disturbed arb", {3'b0, arb}, 4'h1);
    chk("R6 start disturbed busy", {2'b0, st}, 4'h3);
    chk("R7 hold raised", {3'b0, hold}, 4'h1);
    @(negedge clk); sr = 1'b0;
    lines(1'b0, 1'b1);
    chk("R7 hold kept before stop", {3'b0, hold}, 4'h1);
    lines(1'b1, 1'b1);
    chk("R7 hold dropped on stop", {3'b0, hold}, 4'h0);
    chk("R2 stop returns idle", {2'b0, st}, 4'h1);
    @(negedge clk); awr = 1'b1; cyc(); #1 awr = 1'b0;
    chk("R8 addr_wr clears arb", {3'b0, arb}, 4'h0);

    // R9 ACK capture, then rise without ack_phase ignored
    lines(1'b1, 1'b0);
    @(negedge clk); ak = 1'b1; sda = 1'b0; cyc();
    @(negedge clk); scl = 1'b1; cyc();
    chk("R9 ack captured 0", {3'b0, ack}, 4'h0);
    @(negedge clk); ak = 1'b0; sda = 1'b1; scl = 1'b0; cyc();
    lines(1'b1, 1'b1);
    chk("R9 rise without ack_phase ignored", {3'b0, ack}, 4'h0);
    chk("R2 no condition keeps idle", {2'b0, st}, 4'h1);

    // R1 disable, then R4 re-timeout
    @(negedge clk); enable = 1'b0; cyc();
    chk("R1 disabled unknown", {2'b0, st}, 4'h0);
    cyc();
    @(negedge clk); enable = 1'b1;
    repeat (TMO - 1) cyc();
    chk("R4 re-enable still unknown", {2'b0, st}, 4'h0);
    cyc();
    chk("R4 re-enable timeout idle", {2'b0, st}, 4'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule